// File: doc/BRIEF.md
# Streaming Matrix Block Interleaver

This block reorders a stream of samples by treating each group of m·n samples as an m-row by n-column matrix. Incoming samples fill the matrix across each row before moving to the next row; once the matrix is complete, the samples leave down each column before moving to the next column. The row count m and the column count n are run-time inputs, bounded by a synthesis parameter.

Both sides use valid/ready handshakes. Storage is a pair of matrix banks, so that one block can drain while the next one fills. A partly filled block stays in storage between input bursts and is completed by later samples. A flush input drops such a partial block and lets the write side pick up fresh dimensions. Dimensions take effect only at the start of a block. Settings outside the legal range are clamped, and an error flag reports the clamping.

Top module: `ilv_block_interleaver`

## Requirements
- R1: Sample k of a block, counted from 0, goes to row k / n and column k mod n. Output walks row 0..m-1 within column 0, then column 1, and so on, so output position j carries input sample (j mod m)·n + j / m.
- R2: With m=3 and n=5, inputs 0..14 leave in the order 0,5,10,1,6,11,2,7,12,3,8,13,4,9,14.
- R3: outValid stays low while fewer than m·n samples of a block have been accepted.
- R4: Samples past a whole number of blocks are held, and they start the next block. With m=3 and n=4, 27 inputs give two blocks of output and leave 3 samples held, with no output pending. Nine more inputs then complete a third block that begins with the held samples.
- R5: While outValid is high and outReady is low, outValid, outData and outLast stay unchanged.
- R6: While flush is high, inReady is low. A flush drops the partial block being filled. Blocks that are already complete still leave in full.
- R7: A block's dimensions are the clamped cfgRows and cfgCols that are present when its first sample is accepted. Changes after that point do not alter the block.
- R8: outLast is high on the final sample of every block and low on every other output sample.
- R9: A second complete block can be accepted while the first one waits to be read. With two complete blocks waiting, inReady is low.
- R10: A value of 0 for cfgRows or cfgCols is treated as 1, and a value above MAX_DIM (16 by default) is treated as MAX_DIM. cfgErr is high in the cycle after either setting lies outside 1..MAX_DIM, and low in the cycle after both settings are legal.
- R11: After reset, inReady is high, and outValid, outLast and cfgErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops the partial block and reloads the dimensions |
| cfgRows | input | DIM_W | Requested row count m |
| cfgCols | input | DIM_W | Requested column count n |
| inValid | input | 1 | Input sample valid |
| inData | input | DATA_W | Input sample |
| inReady | output | 1 | Input sample accepted when high together with inValid |
| outValid | output | 1 | Output sample valid |
| outData | output | DATA_W | Output sample |
| outLast | output | 1 | Marks the final sample of a block |
| outReady | input | 1 | Downstream accepts the output sample |
| cfgErr | output | 1 | Registered flag: a setting was out of range and was clamped |

## Verification
The write that completes a block sets the bank's full flag on the same edge. outValid is therefore high, with the block's first sample on outData, in the cycle that follows that edge. Each output sample moves on one edge after a handshake. cfgErr follows its inputs after one edge. The bench changes its inputs just after a rising edge and reads the outputs at the falling edge. A scoreboard pops the next expected sample only in a cycle where outValid and outReady are both high at that falling edge. Level checks for stalls, flushes, backpressure and the error flag are taken at the falling edge one register stage after the stimulus that causes them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // write the input sample this cycle
    logic wrBank;  // bank being filled
    logic rdBank;  // bank being drained
    logic rdBusy;  // drained bank holds a complete block
  } ilv_strobe_t;

  // clamp a requested dimension into 1..maxV
  function automatic int unsigned clampDim(int unsigned v, int unsigned maxV);
    if (v == 0) return 1;
    if (v > maxV) return maxV;
    return v;
  endfunction

endpackage

// File: rtl/ilv_datapath.sv
module ilv_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ilv_pkg::ilv_strobe_t strb,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData
);

  logic [DATA_W-1:0] bankData [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrBank == 1'(b))) mem[wrAddr] <= wrData;
    end

    assign bankData[b] = mem[rdAddr];
  end

  assign rdData = bankData[strb.rdBank];

  // R5: a bank being drained is never written, so held output data stays put
  a_r5_no_clobber: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.rdBusy) |-> (strb.wrBank != strb.rdBank));

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl #(
  parameter int MAX_DIM = 16,
  parameter int DIM_W   = 5,
  parameter int ADDR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic [DIM_W-1:0]     cfgRows,
  input  logic [DIM_W-1:0]     cfgCols,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic                 outReady,
  output logic                 outValid,
  output logic                 outLast,
  output logic                 cfgErr,
  output ilv_pkg::ilv_strobe_t strb,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [ADDR_W-1:0]    rdAddr
);

  localparam int PROD_W = 2 * DIM_W;
  localparam logic [DIM_W-1:0] MAX_V = DIM_W'(MAX_DIM);

  logic [DIM_W-1:0]  reqRows, reqCols, curRows, curCols, wrRows, wrCols;
  logic [ADDR_W-1:0] wrCnt;
  logic              wrBank, rdBank;
  logic [1:0]        full;
  logic [DIM_W-1:0]  bankRows [2];
  logic [DIM_W-1:0]  bankCols [2];
  logic [DIM_W-1:0]  rdRow, rdCol, rdRows, rdCols;
  logic [PROD_W-1:0] blkLast, rdProd;
  logic              inFire, outFire, blkDone, rowEnd, colEnd;

  // ---------------- write side ----------------
  always_comb begin
    reqRows = DIM_W'(ilv_pkg::clampDim(32'(cfgRows), MAX_DIM));
    reqCols = DIM_W'(ilv_pkg::clampDim(32'(cfgCols), MAX_DIM));
    // dimensions follow the inputs only while no sample of the block is held
    curRows = (wrCnt == '0) ? reqRows : wrRows;
    curCols = (wrCnt == '0) ? reqCols : wrCols;
    blkLast = PROD_W'(curRows) * PROD_W'(curCols) - PROD_W'(1);
  end

  assign inReady = !flush && !full[wrBank];
  assign inFire  = inValid && inReady;
  assign blkDone = inFire && (PROD_W'(wrCnt) == blkLast);
  assign wrAddr  = wrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt  <= '0;
      wrBank <= 1'b0;
      wrRows <= DIM_W'(1);
      wrCols <= DIM_W'(1);
      for (int b = 0; b < 2; b++) begin
        bankRows[b] <= DIM_W'(1);
        bankCols[b] <= DIM_W'(1);
      end
    end else begin
      wrRows <= curRows;
      wrCols <= curCols;
      if (flush) begin
        wrCnt <= '0;
      end else if (blkDone) begin
        wrCnt            <= '0;
        wrBank           <= ~wrBank;
        bankRows[wrBank] <= curRows;
        bankCols[wrBank] <= curCols;
      end else if (inFire) begin
        wrCnt <= wrCnt + ADDR_W'(1);
      end
    end
  end

  // ---------------- read side ----------------
  always_comb begin
    rdRows   = bankRows[rdBank];
    rdCols   = bankCols[rdBank];
    outValid = full[rdBank];
    rowEnd   = (rdRow == rdRows - DIM_W'(1));
    colEnd   = (rdCol == rdCols - DIM_W'(1));
    outLast  = outValid && rowEnd && colEnd;
    outFire  = outValid && outReady;
    rdProd   = PROD_W'(rdRow) * PROD_W'(rdCols) + PROD_W'(rdCol);
    rdAddr   = ADDR_W'(rdProd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRow  <= '0;
      rdCol  <= '0;
      rdBank <= 1'b0;
    end else if (outFire) begin
      if (rowEnd) begin
        rdRow <= '0;
        if (colEnd) begin
          rdCol  <= '0;
          rdBank <= ~rdBank;
        end else begin
          rdCol <= rdCol + DIM_W'(1);
        end
      end else begin
        rdRow <= rdRow + DIM_W'(1);
      end
    end
  end

  // bank occupancy: the write side sets, the read side clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (blkDone && (wrBank == 1'(b))) full[b] <= 1'b1;
        else if (outFire && outLast && (rdBank == 1'(b))) full[b] <= 1'b0;
      end
    end
  end

  // ---------------- configuration error ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else cfgErr <= (cfgRows == '0) || (cfgRows > MAX_V) ||
                   (cfgCols == '0) || (cfgCols > MAX_V);
  end

  assign strb = '{wrEn: inFire, wrBank: wrBank, rdBank: rdBank, rdBusy: outValid};

  // ---------------- assertions ----------------
  a_r5_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(rdAddr) && $stable(outLast)));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (wrCnt == '0));

  a_r3_full_on_done: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |=> full[$past(wrBank)]);

  a_r8_last_switches: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && outLast) |=> (rdBank != $past(rdBank)));

  a_r1_block_continues: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && !outLast) |=> outValid);

  a_r10_dims_legal: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (rdRows >= DIM_W'(1) && rdRows <= MAX_V &&
                  rdCols >= DIM_W'(1) && rdCols <= MAX_V));

endmodule

// File: rtl/ilv_block_interleaver.sv
module ilv_block_interleaver #(
  parameter int DATA_W  = 8,
  parameter int MAX_DIM = 16,
  localparam int DIM_W  = $clog2(MAX_DIM + 1),
  localparam int DEPTH  = MAX_DIM * MAX_DIM,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [DIM_W-1:0]  cfgRows,
  input  logic [DIM_W-1:0]  cfgCols,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  input  logic              outReady,
  output logic              cfgErr
);

  ilv_pkg::ilv_strobe_t strb;
  logic [ADDR_W-1:0]    wrAddr, rdAddr;

  ilv_ctrl #(.MAX_DIM(MAX_DIM), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .cfgRows(cfgRows), .cfgCols(cfgCols),
    .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .outLast(outLast),
    .cfgErr(cfgErr), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  ilv_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(inData),
    .rdAddr(rdAddr), .rdData(outData)
  );

endmodule

// File: tb/test_ilv_block_interleaver.sv
module test_ilv_block_interleaver;

  localparam int DATA_W = 8;
  localparam int MAXD   = 16;
  localparam int DW     = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rstN, flush, inValid, inReady, outValid, outLast, cfgErr;
  logic outReady;
  logic [DW-1:0] cfgRows, cfgCols;
  logic [DATA_W-1:0] inData, outData;

  always #5 clk = ~clk;

  ilv_block_interleaver #(.DATA_W(DATA_W), .MAX_DIM(MAXD)) i_ilv_block_interleaver (
    .clk(clk), .rstN(rstN), .flush(flush), .cfgRows(cfgRows), .cfgCols(cfgCols),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .outReady(outReady), .cfgErr(cfgErr)
  );

  typedef struct { logic [DATA_W-1:0] d; logic l; } exp_t;
  exp_t expQ[$];
  int   pend[$];
  int   blkM, blkN;
  int   checks = 0, errors = 0;
  string curReq = "R11";
  bit   done = 0;

  // ready pattern: fixed level or a toggling pattern
  logic rdyHold = 1'b0, rdyToggle = 1'b0, tgl = 1'b0;
  int   tcnt = 0;
  assign outReady = rdyToggle ? tgl : rdyHold;
  initial forever begin
    @(posedge clk); #1;
    tcnt++;
    tgl = (tcnt % 3) != 0;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampB(int v);
    if (v == 0) return 1;
    if (v > MAXD) return MAXD;
    return v;
  endfunction

  // reference model: row-wise fill, column-wise drain
  task automatic acceptModel(int v);
    if (pend.size() == 0) begin
      blkM = clampB(int'(cfgRows));
      blkN = clampB(int'(cfgCols));
    end
    pend.push_back(v);
    if (pend.size() == blkM * blkN) begin
      for (int c = 0; c < blkN; c++)
        for (int r = 0; r < blkM; r++) begin
          exp_t e;
          e.d = 8'(pend[r * blkN + c]);
          e.l = (c == blkN - 1) && (r == blkM - 1);
          expQ.push_back(e);
        end
      pend.delete();
    end
  endtask

  task automatic sendOne(int v);
    bit rdy;
    inValid = 1'b1;
    inData  = 8'(v);
    forever begin
      @(negedge clk); rdy = inReady;
      @(posedge clk); #1;
      if (rdy) break;
    end
    acceptModel(v);
  endtask

  task automatic sendRange(int first, int count);
    for (int i = 0; i < count; i++) sendOne(first + i);
    inValid = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 3000 && expQ.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, req, "pending expected samples", expQ.size(), 0);
  endtask

  task automatic setCfg(int r, int c);
    cfgRows = DW'(r);
    cfgCols = DW'(c);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      exp_t e;
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected output sample", int'(outData), -1);
      end else begin
        e = expQ.pop_front();
        check(outData == e.d, curReq, "output sample (R1 order)", int'(outData), int'(e.d));
        check(outLast == e.l, curReq, "outLast (R8)", int'(outLast), int'(e.l));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired in %s actual 0 expected 1", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] heldD;
    logic heldL;
    rstN = 1'b0; flush = 1'b0; inValid = 1'b0; inData = '0;
    setCfg(3, 5);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(inReady == 1'b1, "R11", "inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R11", "outValid", int'(outValid), 0);
    check(outLast == 1'b0, "R11", "outLast", int'(outLast), 0);
    check(cfgErr == 1'b0, "R11", "cfgErr", int'(cfgErr), 0);
    @(posedge clk); #1;

    // R2: 3x5 example order
    curReq = "R2"; rdyHold = 1'b1;
    sendRange(0, 15);
    drain("R2");

    // R1 and R8: 4x2 blocks under a toggling ready pattern
    curReq = "R1"; setCfg(4, 2); rdyToggle = 1'b1;
    sendRange(100, 16);
    drain("R1");
    rdyToggle = 1'b0;

    // R3 and R4: 3x4 with leftovers
    curReq = "R4"; setCfg(3, 4);
    sendRange(0, 11);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R3", "outValid with 11 of 12 held", int'(outValid), 0);
    @(posedge clk); #1;
    sendRange(11, 16);
    drain("R4");
    @(negedge clk);
    check(outValid == 1'b0, "R4", "outValid with 3 samples held", int'(outValid), 0);
    check(pend.size() == 3, "R4", "model held count", pend.size(), 3);
    @(posedge clk); #1;
    sendRange(27, 9);
    drain("R4");

    // R6: flush drops a partial block
    curReq = "R6"; setCfg(2, 2);
    sendRange(50, 2);
    flush = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0, "R6", "inReady during flush", int'(inReady), 0);
    @(posedge clk); #1;
    flush = 1'b0; pend.delete();
    sendRange(200, 4);
    drain("R6");
    // flush with one complete block waiting: that block still leaves
    rdyHold = 1'b0;
    sendRange(60, 5);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0; pend.delete();
    rdyHold = 1'b1;
    drain("R6");
    @(negedge clk);
    check(outValid == 1'b0, "R6", "outValid after flushed partial", int'(outValid), 0);
    @(posedge clk); #1;

    // R7: change dimensions in the middle of a block
    curReq = "R7"; setCfg(2, 3);
    sendOne(70);
    setCfg(4, 4);
    sendRange(71, 5);
    drain("R7");
    @(negedge clk);
    check(outValid == 1'b0, "R7", "outValid after 2x3 block", int'(outValid), 0);
    @(posedge clk); #1;

    // R9 and R5: two blocks waiting, then backpressure
    curReq = "R9"; setCfg(2, 2); rdyHold = 1'b0;
    sendRange(80, 8);
    @(negedge clk);
    check(inReady == 1'b0, "R9", "inReady with two full blocks", int'(inReady), 0);
    check(outValid == 1'b1, "R9", "outValid with two full blocks", int'(outValid), 1);
    check(outData == 8'd80, "R5", "first held sample", int'(outData), 80);
    heldD = outData; heldL = outLast;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b1, "R5", "outValid held", int'(outValid), 1);
    check(outData == heldD, "R5", "outData held", int'(outData), int'(heldD));
    check(outLast == heldL, "R5", "outLast held", int'(outLast), int'(heldL));
    @(posedge clk); #1;
    curReq = "R5"; rdyHold = 1'b1;
    drain("R9");

    // R10: clamping and error flag
    curReq = "R10"; setCfg(20, 1);
    @(posedge clk);
    @(negedge clk);
    check(cfgErr == 1'b1, "R10", "cfgErr for 20 rows", int'(cfgErr), 1);
    @(posedge clk); #1;
    sendRange(120, 16);
    drain("R10");
    setCfg(0, 2);
    @(posedge clk);
    @(negedge clk);
    check(cfgErr == 1'b1, "R10", "cfgErr for 0 rows", int'(cfgErr), 1);
    @(posedge clk); #1;
    sendRange(140, 2);
    drain("R10");
    setCfg(3, 3);
    @(posedge clk);
    @(negedge clk);
    check(cfgErr == 1'b0, "R10", "cfgErr for legal setting", int'(cfgErr), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule